// File: doc/BRIEF.md
# Q1.15 Sequential FIR Filter Core

This core filters a stream of signed 16-bit Q1.15 samples with a finite impulse response whose tap count is set by a parameter. A host loads the coefficients through a one-cycle write port. The core accepts a sample on a valid strobe and stores it in a circular delay line. It then spends one clock per coefficient, multiplying and adding into a signed accumulator wide enough that it cannot overflow. After the last tap it rounds half an output LSB upward, shifts arithmetically back to Q1.15, clamps to the 16-bit range, and presents the result with a one-cycle valid pulse.

When the symmetric option is enabled, the core assumes linear-phase coefficients. It stores only the first half of the taps, including the middle tap when the tap count is odd. The two samples that share a coefficient are added before the multiply, so the core needs about half as many multiply cycles for each output. While the core is computing, it holds a busy flag and discards further input strobes.

Top module: `q15_fir`

## Requirements
- R1: After reset is released, `busy_o` and `out_valid_o` are low, `out_data_o` is zero, and every delay-line entry holds zero. The first outputs therefore act as if all earlier inputs were zero.
- R2: When `coef_we_i` is high at a clock edge, the core stores `coef_data_i` as coefficient h[`coef_addr_i`]. It ignores a write whose address is at or above the number of stored coefficients: NTAPS in plain mode, ceil(NTAPS/2) in symmetric mode.
- R3: The core accepts a sample when `in_valid_i` is high at an edge where `busy_o` is low, and `busy_o` is high from the next cycle on.
- R4: The core ignores an `in_valid_i` strobe that arrives while `busy_o` is high, and the ignored sample never enters the delay line. Between output pulses, `out_data_o` holds its value.
- R5: `out_valid_o` pulses for exactly one cycle. The pulse comes C cycles after the accepting edge, where C is the number of stored coefficients, and `busy_o` falls in the same cycle.
- R6: In plain mode the output is y = (sum over k of h[k]*x[n-k] + 2^14) >>> 15, where x[n] is the newest accepted sample and k runs from 0 to NTAPS-1. Halves round toward positive infinity.
- R7: When the shifted result is above 32767 the output is 32767, and when it is below -32768 the output is -32768. The output never wraps.
- R8: The delay line is circular. Each accepted sample replaces the oldest one, and only the last NTAPS accepted samples affect the output.
- R9: In symmetric mode, tap k and tap NTAPS-1-k both use the stored h[k]. Their samples are added before the multiply, and when NTAPS is odd the middle tap is applied only once. The arithmetic otherwise follows R6 and R7.
- R10: The accumulator does not overflow for any inputs. For example, five products of (-1)*(-1), which sum to more than 2^31, still produce the positive saturated output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | $clog2(NTAPS) | Coefficient index |
| coef_data_i | input | DW (16) | Coefficient value, Q1.15 |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | DW (16) | Input sample, Q1.15 |
| busy_o | output | 1 | High while a sum is being computed |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | DW (16) | Filtered sample, Q1.15 |

## Verification
The assertions check the handshake on every cycle. Busy rises after an accepted strobe and ends only with a result. The result pulse lasts one cycle and never overlaps busy. The output holds between pulses, and a counter in the checker confirms that each busy period lasts exactly one cycle per stored coefficient. The arithmetic is shown only by the bench's scenarios: the half-LSB rounding of small values, saturation at both rails, the wide-accumulator case, the circular history, the mirrored coefficients of the symmetric variant, and the discarding of ignored writes and strobes. The bench compares these against a model that computes the expected sums.

// File: rtl/q15_fir_pkg.sv
package q15_fir_pkg;
  localparam int unsigned SAMPLE_W = 16;

  function automatic int unsigned stored_taps(input int unsigned ntaps, input bit sym);
    return sym ? (ntaps + 1) / 2 : ntaps;
  endfunction
endpackage

// File: rtl/q15_fir_delay.sv
module q15_fir_delay #(
  parameter int NTAPS     = 8,
  parameter int DW        = 16,
  parameter bit SYMMETRIC = 1'b0,
  parameter int PW        = $clog2(NTAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic [PW-1:0]        tap_i,
  output logic signed [DW:0]   opnd_o
);
  localparam int DEPTH = 1 << PW;
  localparam logic [PW:0]   NV   = (PW+1)'(NTAPS);
  localparam logic [PW-1:0] LAST = PW'(NTAPS - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, head_nx;

  assign head_nx = (head_q == LAST) ? '0 : head_q + 1'b1;

  // slot holding x[n-off]
  function automatic logic [PW-1:0] slot(input logic [PW-1:0] hd, input logic [PW-1:0] off);
    logic [PW:0] s;
    s = {1'b0, hd} + NV - {1'b0, off};
    if (s >= NV) s = s - NV;
    return s[PW-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      head_q          <= head_nx;
      mem_q[head_nx]  <= wr_data_i;
    end
  end

  logic [DW-1:0] rd_a;
  assign rd_a = mem_q[slot(head_q, tap_i)];

  if (SYMMETRIC) begin : g_sym
    localparam bit ODD = (NTAPS % 2) == 1;
    localparam logic [PW-1:0] MID = PW'((NTAPS - 1) / 2);
    logic [DW-1:0] rd_b;
    logic          mid;
    assign rd_b   = mem_q[slot(head_q, LAST - tap_i)];
    assign mid    = ODD && (tap_i == MID);
    assign opnd_o = mid ? $signed({rd_a[DW-1], rd_a})
                        : $signed({rd_a[DW-1], rd_a}) + $signed({rd_b[DW-1], rd_b});
  end else begin : g_plain
    assign opnd_o = $signed({rd_a[DW-1], rd_a});
  end
endmodule

// File: rtl/q15_fir_coef.sv
module q15_fir_coef #(
  parameter int NCOEF = 8,
  parameter int DW    = 16,
  parameter int AW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] NC = (AW+1)'(NCOEF);

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && ({1'b0, wr_addr_i} < NC)) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/q15_fir_round_sat.sv
module q15_fir_round_sat #(
  parameter int ACC_W = 36,
  parameter int DW    = 16
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic        [DW-1:0]    y_o
);
  localparam int FRAC = DW - 1;
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (DW - 2);
  localparam logic signed [ACC_W:0] MAXV = ((ACC_W+1)'(1) <<< FRAC) - 1;
  localparam logic signed [ACC_W:0] MINV = ~MAXV;

  logic signed [ACC_W:0] biased, shifted;

  assign biased  = (ACC_W+1)'(acc_i) + HALF;
  assign shifted = biased >>> FRAC;

  always_comb begin
    if (shifted > MAXV)      y_o = {1'b0, {(DW-1){1'b1}}};
    else if (shifted < MINV) y_o = {1'b1, {(DW-1){1'b0}}};
    else                     y_o = shifted[DW-1:0];
  end
endmodule

// File: rtl/q15_fir.sv
module q15_fir #(
  parameter int NTAPS     = 8,
  parameter bit SYMMETRIC = 1'b0,
  parameter int DW        = q15_fir_pkg::SAMPLE_W,
  parameter int AW        = $clog2(NTAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          coef_we_i,
  input  logic [AW-1:0] coef_addr_i,
  input  logic [DW-1:0] coef_data_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          busy_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o
);
  localparam int NCOEF  = int'(q15_fir_pkg::stored_taps(NTAPS, SYMMETRIC));
  localparam int PROD_W = 2 * DW + 1;
  localparam int ACC_W  = PROD_W + $clog2(NCOEF) + 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(NCOEF - 1);

  logic                     run_q, start, last;
  logic [AW-1:0]            idx_q;
  logic signed [ACC_W-1:0]  acc_q, acc_nx;
  logic [DW-1:0]            coef;
  logic signed [DW:0]       opnd;
  logic signed [PROD_W-1:0] prod;
  logic [DW-1:0]            y_rnd;

  assign start = in_valid_i && !run_q;
  assign last  = idx_q == LAST_IDX;

  q15_fir_coef #(.NCOEF(NCOEF), .DW(DW), .AW(AW)) u_coef (
    .clk_i, .rst_ni,
    .we_i(coef_we_i), .wr_addr_i(coef_addr_i), .wr_data_i(coef_data_i),
    .rd_addr_i(idx_q), .rd_data_o(coef)
  );

  q15_fir_delay #(.NTAPS(NTAPS), .DW(DW), .SYMMETRIC(SYMMETRIC), .PW(AW)) u_delay (
    .clk_i, .rst_ni,
    .wr_en_i(start), .wr_data_i(in_data_i),
    .tap_i(idx_q), .opnd_o(opnd)
  );

  assign prod   = PROD_W'($signed(coef)) * PROD_W'(opnd);
  assign acc_nx = acc_q + ACC_W'(prod);

  q15_fir_round_sat #(.ACC_W(ACC_W), .DW(DW)) u_rnd (.acc_i(acc_nx), .y_o(y_rnd));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      idx_q       <= '0;
      acc_q       <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (!run_q) begin
        if (in_valid_i) begin
          run_q <= 1'b1;
          idx_q <= '0;
          acc_q <= '0;
        end
      end else begin
        acc_q <= acc_nx;
        idx_q <= idx_q + 1'b1;
        if (last) begin
          run_q       <= 1'b0;
          out_valid_o <= 1'b1;
          out_data_o  <= y_rnd;
        end
      end
    end
  end

  assign busy_o = run_q;
endmodule

// File: rtl/q15_fir_chk.sv
module q15_fir_chk #(
  parameter int NTAPS     = 8,
  parameter bit SYMMETRIC = 1'b0,
  parameter int DW        = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          busy_o,
  input logic          out_valid_o,
  input logic [DW-1:0] out_data_o
);
  localparam int NCOEF = int'(q15_fir_pkg::stored_taps(NTAPS, SYMMETRIC));
  localparam int CW    = $clog2(NCOEF + 1) + 1;
  localparam logic [CW-1:0] NCV = CW'(NCOEF);

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r3_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !busy_o) |=> busy_o);
  a_r4_busy_ends_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !out_valid_o) |=> (busy_o || out_valid_o));
  a_r4_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !busy_o);
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (busy_cnt == NCV));
endmodule

bind q15_fir q15_fir_chk #(.NTAPS(NTAPS), .SYMMETRIC(SYMMETRIC), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .busy_o(busy_o), .out_valid_o(out_valid_o), .out_data_o(out_data_o)
);

// File: tb/q15_fir_bench.sv
module q15_fir_bench;
  localparam int N  = 5;
  localparam int NS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, in_v = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] cdata = '0, in_d = '0;
  logic busy_p, ov_p, busy_s, ov_s;
  logic [15:0] od_p, od_s;

  int errs = 0, checks = 0;
  int hist [N];
  int coef [N];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  q15_fir #(.NTAPS(N), .SYMMETRIC(1'b0)) u_q15_fir (
    .clk_i(clk), .rst_ni(rst_n), .coef_we_i(we), .coef_addr_i(addr), .coef_data_i(cdata),
    .in_valid_i(in_v), .in_data_i(in_d), .busy_o(busy_p), .out_valid_o(ov_p), .out_data_o(od_p));

  q15_fir #(.NTAPS(N), .SYMMETRIC(1'b1)) u_q15_fir_sym (
    .clk_i(clk), .rst_ni(rst_n), .coef_we_i(we), .coef_addr_i(addr), .coef_data_i(cdata),
    .in_valid_i(in_v), .in_data_i(in_d), .busy_o(busy_s), .out_valid_o(ov_s), .out_data_o(od_s));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input bit sym);
    longint acc = 0, y;
    for (int k = 0; k < N; k++) begin
      int h;
      h = sym ? coef[(k < NS) ? k : N - 1 - k] : coef[k];
      acc += longint'(h) * longint'(hist[k]);
    end
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic wr_coef(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = a[2:0]; cdata = d[15:0];
    @(negedge clk);
    we = 1'b0;
    if (a < N) coef[a] = int'($signed(d[15:0]));
  endtask

  // one sample through both cores; inject = strobe junk while busy (R4)
  task automatic send(input int x, input bit inject, input string req_p, input string req_s);
    int yp = 0, ys = 0;
    @(negedge clk);
    in_v = 1'b1; in_d = x[15:0];
    @(negedge clk);
    check("R3 busy plain", int'(busy_p), 1);
    check("R3 busy sym", int'(busy_s), 1);
    if (inject) in_d = 16'h7fff; else in_v = 1'b0;
    for (int i = N - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = int'($signed(x[15:0]));
    for (int c = 1; c <= N; c++) begin
      @(negedge clk);
      in_v = 1'b0;
      check("R5 plain valid timing", int'(ov_p), int'(c == N));
      if (c <= NS) check("R5 sym valid timing", int'(ov_s), int'(c == NS));
      if (ov_p) yp = int'($signed(od_p));
      if (ov_s) ys = int'($signed(od_s));
    end
    check("R5 idle after", int'(busy_p | busy_s), 0);
    check(req_p, yp, model(1'b0));
    check(req_s, ys, model(1'b1));
  endtask

  initial begin
    #(4 * 100000);
    errs++; checks++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin hist[i] = 0; coef[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", int'(busy_p | busy_s), 0);
    check("R1 valid", int'(ov_p | ov_s), 0);
    check("R1 data", int'(od_p | od_s), 0);

    // R2: out-of-range writes ignored, h0 = 0.5
    wr_coef(0, 16'h4000);
    wr_coef(7, 16'h1234);
    wr_coef(5, 16'h2222);
    send(1, 1'b0, "R8 zero history plain", "R2 R9 sym");
    send(-1, 1'b0, "R6 rounding -1", "R9 sym");
    send(3, 1'b0, "R6 rounding 3", "R9 sym");
    send(-3, 1'b0, "R6 rounding -3", "R9 sym");

    // R2 R8 R9: sym ignores addresses 3,4
    for (int a = 0; a < N; a++) wr_coef(a, rnd16());
    for (int s = 0; s < 24; s++)
      send(rnd16(), s[0], "R6 R8 plain sweep", "R2 R9 sym sweep");

    // R7 R10 saturation
    for (int a = 0; a < N; a++) wr_coef(a, 16'h7fff);
    for (int s = 0; s < N; s++) send(16'h7fff, 1'b0, "R7 positive rail", "R7 R9 positive rail");
    for (int s = 0; s < N; s++) send(16'h8000, 1'b1, "R7 negative rail", "R7 R9 negative rail");
    for (int a = 0; a < N; a++) wr_coef(a, 16'h8000);
    send(16'h8000, 1'b0, "R10 wide accumulator", "R10 R9 wide accumulator");
    send(16'h0001, 1'b0, "R8 circular overwrite", "R9 sym");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule